// File: doc/BRIEF.md
# Dual-Pipe Instruction Pairing Controller

This controller sits behind an in-order decoder. Each cycle it decides whether the two oldest decoded instructions start together, the older one in the primary pipe (U) and the younger in the secondary pipe (V), or whether only the older one starts, or whether nothing starts. It looks at a two-slot window of pre-decoded descriptors.

Each descriptor says whether the instruction can pair at all and which register it writes. The younger slot also lists the registers it reads. A descriptor further says whether the instruction is a read-modify-write on memory, how many prefix bytes precede it, and whether one of those bytes is the two-byte-opcode escape of a near conditional jump. It also says whether the code is running for the first time since it was cached. The older slot also gives its length in bytes.

The decision has state. Prefix bytes take up cycles of their own in U. Read-modify-write memory operations keep their pipe busy for several cycles. When two such operations pair, the V operation starts only as the U operation finishes. The consumer shifts its window by the reported advance count at each rising clock edge.

Top module: `pair_issue_ctrl`

## Requirements
- R1: While `rst_n` is low, `issue_u`, `issue_v` and `prefix_cycle` are 0 and `advance` is 0. The reset is synchronous and clears all prefix and occupancy state, so the first valid window after reset is decided as if the pipes were idle.
- R2: When both slots are valid and pairable, and no hazard or restriction below applies, `issue_u` and `issue_v` are both 1 and `advance` is 2 in the same cycle.
- R3: If either slot is not pairable, only the older instruction starts: `issue_u`=1, `issue_v`=0, `advance`=1.
- R4: Register numbers are 3-bit codes 0..7. The pair is refused, and only U starts, when the older slot writes (`s0_wr_en`=1) a register that the younger slot reads through `s1_src_a` or `s1_src_b`. The pair is also refused when both slots write the same register. A matching number has no effect when `s0_wr_en`=0.
- R5: An older instruction with N counted prefix cycles first spends N cycles with `prefix_cycle`=1, both issue strobes at 0 and `advance`=0. In the next cycle it starts in U and may pair with the younger slot.
- R6: When `s0_esc`=1 and `s0_pfx_n`≥1, one of the counted prefix bytes is the conditional-jump escape. That byte costs no cycle, so N = `s0_pfx_n` − 1.
- R7: A younger instruction that still has prefix cycles to pay (`s1_pfx_n` minus its escape byte, as in R6, is not 0) cannot start in V. Only U starts.
- R8: After a lone read-modify-write memory instruction starts in U, nothing starts and no prefix cycle is counted for the next MEM_OCC−1 cycles (2 by default).
- R9: When both paired instructions are read-modify-write memory operations, V runs after U with one cycle of overlap. Nothing starts for the next 2·MEM_OCC−2 cycles (4 by default).
- R10: If `s0_cold` or `s1_cold` is 1, a pair is allowed only when `s0_len` equals 1.
- R11: When `s1_valid`=0, the controller starts at most one instruction. When `s0_valid`=0, nothing starts and `advance`=0.
- R12: When only the V instruction of a pair is a read-modify-write memory operation, nothing starts for the next MEM_OCC−1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_pairable | input | 1 | Older instruction is of a pairable class |
| s0_memrmw | input | 1 | Older instruction is a read-modify-write on memory |
| s0_wr_en | input | 1 | Older instruction writes `s0_dst` |
| s0_dst | input | 3 | Register written by the older instruction |
| s0_pfx_n | input | 2 | Prefix byte count of the older instruction |
| s0_esc | input | 1 | One older prefix is a conditional-jump escape |
| s0_len | input | 4 | Older instruction length in bytes |
| s0_cold | input | 1 | Older instruction runs for the first time since it was cached |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_pairable | input | 1 | Younger instruction is of a pairable class |
| s1_memrmw | input | 1 | Younger instruction is a read-modify-write on memory |
| s1_wr_en | input | 1 | Younger instruction writes `s1_dst` |
| s1_dst | input | 3 | Register written by the younger instruction |
| s1_src_a | input | 3 | First register read by the younger instruction |
| s1_src_b | input | 3 | Second register read by the younger instruction |
| s1_pfx_n | input | 2 | Prefix byte count of the younger instruction |
| s1_esc | input | 1 | One younger prefix is a conditional-jump escape |
| s1_cold | input | 1 | Younger instruction runs for the first time since it was cached |
| issue_u | output | 1 | Older instruction starts in U this cycle |
| issue_v | output | 1 | Younger instruction starts in V this cycle |
| prefix_cycle | output | 1 | U is consuming one prefix byte this cycle |
| advance | output | 2 | Slots to retire from the window: 0, 1 or 2 |

## Verification
A wrong internal state shows up on the issue strobes. A prefix counter that is off by one moves the start of U a cycle earlier or later. It also changes how many cycles have `prefix_cycle` high. Occupancy counters loaded with the wrong value or left stale open or close the stall window at the wrong cycle. This becomes visible within at most 2·MEM_OCC−1 cycles of the memory operation starting. A stale counter after reset blocks the first window after reset from starting, so the error is visible in the first cycle after reset is released.

// File: rtl/pair_pkg.sv
// pair_pkg: shared widths, field types and helpers for the pairing controller.
// Assumes at most three prefix bytes per instruction and eight tracked registers.
package pair_pkg;
    localparam int REG_W = 3;
    localparam int PFX_W = 2;
    localparam int LEN_W = 4;

    typedef logic [REG_W-1:0] reg_t;
    typedef logic [PFX_W-1:0] pfx_t;
    typedef logic [LEN_W-1:0] len_t;

    // Prefix cycles actually paid: the conditional-jump escape byte is free.
    function automatic pfx_t paid_prefix(input pfx_t n, input logic esc);
        return (esc && (n != '0)) ? pfx_t'(n - pfx_t'(1)) : n;
    endfunction
endpackage

// File: rtl/pair_check.sv
// pair_check: combinational test of whether the younger slot may start in V
// beside the older one. Assumes the older slot is valid; the caller gates
// with start readiness. Checks class, register contention, younger-slot
// prefixes and the first-execution length rule.
module pair_check
    import pair_pkg::*;
(
    input  logic s0_pairable,
    input  logic s0_wr_en,
    input  reg_t s0_dst,
    input  len_t s0_len,
    input  logic s0_cold,
    input  logic s1_valid,
    input  logic s1_pairable,
    input  logic s1_wr_en,
    input  reg_t s1_dst,
    input  reg_t s1_src_a,
    input  reg_t s1_src_b,
    input  pfx_t s1_pfx_n,
    input  logic s1_esc,
    input  logic s1_cold,
    output logic pair_ok
);
    logic raw_hit, waw_hit, cold_ok, v_pfx_free;

    // Decide pair eligibility from the two descriptors.
    always_comb begin
        raw_hit    = s0_wr_en && ((s1_src_a == s0_dst) || (s1_src_b == s0_dst));
        waw_hit    = s0_wr_en && s1_wr_en && (s1_dst == s0_dst);
        cold_ok    = !(s0_cold || s1_cold) || (s0_len == len_t'(1));
        v_pfx_free = (paid_prefix(s1_pfx_n, s1_esc) == '0);
        pair_ok    = s1_valid && s0_pairable && s1_pairable && !raw_hit
                     && !waw_hit && cold_ok && v_pfx_free;
    end
endmodule

// File: rtl/pair_prefix_seq.sv
// pair_prefix_seq: counts the prefix cycles the older instruction spends in U.
// Assumes the window holds still while advance is 0. The count is cleared
// when the instruction starts. Synchronous active-low reset.
module pair_prefix_seq
    import pair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  pfx_t pfx_n,
    input  logic esc,
    output logic pfx_cycle,
    output logic ready
);
    pfx_t used_q;
    pfx_t need;

    // Compare the cycles already spent with the cycles the prefixes require.
    always_comb begin
        need      = paid_prefix(pfx_n, esc);
        pfx_cycle = go && (used_q < need);
        ready     = go && (used_q >= need);
    end

    // Step the count on each prefix cycle and clear it when the instruction starts.
    always_ff @(posedge clk) begin
        if (!rst_n)         used_q <= '0;
        else if (pfx_cycle) used_q <= used_q + pfx_t'(1);
        else if (ready)     used_q <= '0;
    end
endmodule

// File: rtl/pair_occupancy.sv
// pair_occupancy: one busy counter per pipe for multi-cycle memory
// read-modify-write operations. A paired V operation is delayed until U
// is in its last cycle. The controller is idle when both counters are zero.
module pair_occupancy #(
    parameter int MEM_OCC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_u,
    input  logic start_v,
    input  logic mem_u,
    input  logic mem_v,
    output logic idle
);
    localparam int SER_OCC = 2 * MEM_OCC - 2;
    localparam int OCC_W   = $clog2(SER_OCC + 1);
    typedef logic [OCC_W-1:0] occ_t;

    occ_t u_q, v_q;

    // No new work may start while either pipe is still occupied.
    always_comb idle = (u_q == '0) && (v_q == '0);

    // Load the counters when work starts, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_q <= '0;
            v_q <= '0;
        end else if (start_u) begin
            u_q <= mem_u ? occ_t'(MEM_OCC - 1) : '0;
            if (start_v && mem_v)
                v_q <= mem_u ? occ_t'(SER_OCC) : occ_t'(MEM_OCC - 1);
            else
                v_q <= '0;
        end else begin
            if (u_q != '0) u_q <= u_q - occ_t'(1);
            if (v_q != '0) v_q <= v_q - occ_t'(1);
        end
    end
endmodule

// File: rtl/pair_issue_ctrl.sv
// pair_issue_ctrl: per-cycle pairing decision for a two-slot in-order window.
// Assumes the consumer shifts its window by 'advance' at each rising edge.
// Synchronous active-low reset; the outputs are forced low while reset is held.
module pair_issue_ctrl
    import pair_pkg::*;
#(
    parameter int MEM_OCC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s0_valid,
    input  logic       s0_pairable,
    input  logic       s0_memrmw,
    input  logic       s0_wr_en,
    input  logic [2:0] s0_dst,
    input  logic [1:0] s0_pfx_n,
    input  logic       s0_esc,
    input  logic [3:0] s0_len,
    input  logic       s0_cold,
    input  logic       s1_valid,
    input  logic       s1_pairable,
    input  logic       s1_memrmw,
    input  logic       s1_wr_en,
    input  logic [2:0] s1_dst,
    input  logic [2:0] s1_src_a,
    input  logic [2:0] s1_src_b,
    input  logic [1:0] s1_pfx_n,
    input  logic       s1_esc,
    input  logic       s1_cold,
    output logic       issue_u,
    output logic       issue_v,
    output logic       prefix_cycle,
    output logic [1:0] advance
);
    logic pair_ok, idle, pfx_cyc, ready;

    pair_check chk_u (
        .s0_pairable (s0_pairable),
        .s0_wr_en    (s0_wr_en),
        .s0_dst      (s0_dst),
        .s0_len      (s0_len),
        .s0_cold     (s0_cold),
        .s1_valid    (s1_valid),
        .s1_pairable (s1_pairable),
        .s1_wr_en    (s1_wr_en),
        .s1_dst      (s1_dst),
        .s1_src_a    (s1_src_a),
        .s1_src_b    (s1_src_b),
        .s1_pfx_n    (s1_pfx_n),
        .s1_esc      (s1_esc),
        .s1_cold     (s1_cold),
        .pair_ok     (pair_ok)
    );

    pair_prefix_seq pfx_u (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (rst_n && s0_valid && idle),
        .pfx_n     (s0_pfx_n),
        .esc       (s0_esc),
        .pfx_cycle (pfx_cyc),
        .ready     (ready)
    );

    pair_occupancy #(.MEM_OCC(MEM_OCC)) occ_u (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_u (issue_u),
        .start_v (issue_v),
        .mem_u   (s0_memrmw),
        .mem_v   (s1_memrmw),
        .idle    (idle)
    );

    // Form the strobes and the window advance from the sub-block decisions.
    always_comb begin
        issue_u      = rst_n && ready;
        issue_v      = issue_u && pair_ok;
        prefix_cycle = rst_n && pfx_cyc;
        advance      = {1'b0, issue_u} + {1'b0, issue_v};
    end
endmodule

// File: rtl/pair_issue_ctrl_chk.sv
// pair_issue_ctrl_chk: temporal checks on the pairing controller's ports,
// attached by bind. Assumes the default occupancy of three cycles.
module pair_issue_ctrl_chk
    import pair_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       s0_valid,
    input logic       s0_pairable,
    input logic       s0_memrmw,
    input logic       s0_wr_en,
    input logic [2:0] s0_dst,
    input logic [3:0] s0_len,
    input logic       s0_cold,
    input logic       s1_valid,
    input logic       s1_pairable,
    input logic       s1_memrmw,
    input logic [2:0] s1_src_a,
    input logic [2:0] s1_src_b,
    input logic [1:0] s1_pfx_n,
    input logic       s1_esc,
    input logic       s1_cold,
    input logic       issue_u,
    input logic       issue_v,
    input logic       prefix_cycle,
    input logic [1:0] advance
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!issue_u && !issue_v && !prefix_cycle && advance == 2'd0));

    p_v_with_u_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_v |-> (issue_u && advance == 2'd2));

    p_nonpair_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_u && !(s0_pairable && s1_pairable)) |-> !issue_v);

    p_no_raw_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_wr_en && (s1_src_a == s0_dst || s1_src_b == s0_dst)) |-> !issue_v);

    p_prefix_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prefix_cycle |-> (!issue_u && !issue_v && advance == 2'd0));

    p_v_no_prefix_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_v |-> (paid_prefix(s1_pfx_n, s1_esc) == '0));

    p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_u && !issue_v && s0_memrmw) |=> (!issue_u && !prefix_cycle) ##1 (!issue_u && !prefix_cycle));

    p_mem_serial_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_v && s0_memrmw && s1_memrmw) |=> !issue_u ##1 !issue_u ##1 !issue_u ##1 !issue_u);

    p_cold_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_v && (s0_cold || s1_cold)) |-> (s0_len == 4'd1));

    p_window_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_u |-> s0_valid) and (issue_v |-> s1_valid));

    p_v_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_v && s1_memrmw && !s0_memrmw) |=> !issue_u ##1 !issue_u);
endmodule

bind pair_issue_ctrl pair_issue_ctrl_chk chk_i (.*);

// File: tb/pair_issue_ctrl_tb_top.sv
// Scoreboard bench: the driver presents a window each cycle and queues the
// expected outputs; the monitor compares them at the falling edge.
module pair_issue_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0_valid, s0_pairable, s0_memrmw, s0_wr_en, s0_esc, s0_cold;
    logic [2:0] s0_dst;
    logic [1:0] s0_pfx_n;
    logic [3:0] s0_len;
    logic s1_valid, s1_pairable, s1_memrmw, s1_wr_en, s1_esc, s1_cold;
    logic [2:0] s1_dst, s1_src_a, s1_src_b;
    logic [1:0] s1_pfx_n;
    logic issue_u, issue_v, prefix_cycle;
    logic [1:0] advance;

    typedef struct {
        logic       u;
        logic       v;
        logic       p;
        logic [1:0] adv;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_issue_ctrl dut_i (.*);

    // Plain pairable window with no dependences.
    task automatic dflt();
        s0_valid = 1; s0_pairable = 1; s0_memrmw = 0; s0_wr_en = 1; s0_dst = 3'd1;
        s0_pfx_n = 0; s0_esc = 0; s0_len = 4'd2; s0_cold = 0;
        s1_valid = 1; s1_pairable = 1; s1_memrmw = 0; s1_wr_en = 1; s1_dst = 3'd2;
        s1_src_a = 3'd3; s1_src_b = 3'd4; s1_pfx_n = 0; s1_esc = 0; s1_cold = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        dflt();
    endtask

    task automatic push(input logic u, input logic v, input logic p, input logic [1:0] a, input string tag);
        exp_t e;
        e.u = u; e.v = v; e.p = p; e.adv = a; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare the design outputs with the oldest expectation.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (issue_u !== e.u || issue_v !== e.v || prefix_cycle !== e.p || advance !== e.adv) begin
                errors++;
                $display("FAIL %s: got u=%b v=%b p=%b adv=%0d expected u=%b v=%b p=%b adv=%0d",
                         e.tag, issue_u, issue_v, prefix_cycle, advance, e.u, e.v, e.p, e.adv);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        dflt();
        // R1: outputs quiet while reset is held
        tick(); rst_n = 0; push(0, 0, 0, 2'd0, "R1 reset");
        tick(); rst_n = 0; s0_pfx_n = 2; push(0, 0, 0, 2'd0, "R1 reset prefix");
        // R2: plain pair
        tick(); rst_n = 1; push(1, 1, 0, 2'd2, "R2 pair");
        // R3: either slot not pairable
        tick(); s0_pairable = 0; push(1, 0, 0, 2'd1, "R3 s0 unpairable");
        tick(); s1_pairable = 0; push(1, 0, 0, 2'd1, "R3 s1 unpairable");
        // R4: register contention
        tick(); s1_src_a = 3'd1; push(1, 0, 0, 2'd1, "R4 raw src_a");
        tick(); s1_src_b = 3'd1; push(1, 0, 0, 2'd1, "R4 raw src_b");
        tick(); s1_dst = 3'd1; push(1, 0, 0, 2'd1, "R4 waw");
        tick(); s0_wr_en = 0; s1_src_a = 3'd1; push(1, 1, 0, 2'd2, "R4 no write no hazard");
        // R5: two prefix cycles, then start and pair
        tick(); s0_pfx_n = 2; push(0, 0, 1, 2'd0, "R5 prefix 1");
        tick(); s0_pfx_n = 2; push(0, 0, 1, 2'd0, "R5 prefix 2");
        tick(); s0_pfx_n = 2; push(1, 1, 0, 2'd2, "R5 start after prefix");
        tick(); push(1, 1, 0, 2'd2, "R5 count cleared");
        // R6: escape byte is free
        tick(); s0_pfx_n = 1; s0_esc = 1; push(1, 1, 0, 2'd2, "R6 escape only");
        tick(); s0_pfx_n = 2; s0_esc = 1; push(0, 0, 1, 2'd0, "R6 escape plus one");
        tick(); s0_pfx_n = 2; s0_esc = 1; push(1, 1, 0, 2'd2, "R6 start");
        // R7: prefixed younger instruction stays out of V
        tick(); s1_pfx_n = 1; push(1, 0, 0, 2'd1, "R7 prefixed s1");
        tick(); s1_pfx_n = 1; s1_esc = 1; push(1, 1, 0, 2'd2, "R7 escaped s1 pairs");
        // R8: lone memory op holds U, prefix counting waits
        tick(); s0_memrmw = 1; s1_valid = 0; push(1, 0, 0, 2'd1, "R8 mem start");
        tick(); s0_pfx_n = 1; push(0, 0, 0, 2'd0, "R8 busy 1");
        tick(); s0_pfx_n = 1; push(0, 0, 0, 2'd0, "R8 busy 2");
        tick(); s0_pfx_n = 1; push(0, 0, 1, 2'd0, "R8 prefix after busy");
        tick(); s0_pfx_n = 1; push(1, 1, 0, 2'd2, "R8 start after busy");
        // R9: serialized memory pair
        tick(); s0_memrmw = 1; s1_memrmw = 1; push(1, 1, 0, 2'd2, "R9 mem pair");
        for (int k = 0; k < 4; k++) begin
            tick(); push(0, 0, 0, 2'd0, "R9 serial busy");
        end
        tick(); push(1, 1, 0, 2'd2, "R9 start after serial");
        // R1: reset clears occupancy
        tick(); s0_memrmw = 1; s1_memrmw = 1; push(1, 1, 0, 2'd2, "R1 mem pair before reset");
        tick(); rst_n = 0; push(0, 0, 0, 2'd0, "R1 reset mid busy");
        tick(); rst_n = 1; push(1, 1, 0, 2'd2, "R1 idle after reset");
        // R10: first-execution length rule
        tick(); s0_cold = 1; s0_len = 4'd1; push(1, 1, 0, 2'd2, "R10 cold len1");
        tick(); s0_cold = 1; s0_len = 4'd2; push(1, 0, 0, 2'd1, "R10 cold len2");
        tick(); s1_cold = 1; s0_len = 4'd3; push(1, 0, 0, 2'd1, "R10 s1 cold");
        tick(); s0_len = 4'd3; push(1, 1, 0, 2'd2, "R10 warm len3");
        // R11: partial window
        tick(); s1_valid = 0; push(1, 0, 0, 2'd1, "R11 s1 missing");
        tick(); s0_valid = 0; push(0, 0, 0, 2'd0, "R11 s0 missing");
        // R12: V-only memory op
        tick(); s1_memrmw = 1; push(1, 1, 0, 2'd2, "R12 v mem");
        tick(); push(0, 0, 0, 2'd0, "R12 busy 1");
        tick(); push(0, 0, 0, 2'd0, "R12 busy 2");
        tick(); push(1, 1, 0, 2'd2, "R12 start after busy");
        tick();
        tick();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule